// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU sequencer and decides, at each instruction boundary, whether to divert the program into an interrupt handler. It keeps three words: an enable mask, a pending word, and a holding word (the accumulator). Requests come from two places. Devices raise a bit vector, and a memory parity-error line drives channel 15 directly. Software posts bits through a separate path. There are fifteen channels, numbered 1 to 15. Bit 0 of every word is reserved.

When interrupts are enabled and an enabled channel is pending at a boundary, the channel with the highest number wins. On the next cycle the block emits a one-cycle dispatch strobe. The strobe carries the channel number, the fixed PC save address (octal 500), the PC value to store there, and the address of the handler pointer. The handler pointer table starts at octal 501 and is stored in reverse channel order. The same dispatch disables further interrupts. Software must re-enable interrupts with an enable command.

The two request paths behave differently. Device requests that arrive while interrupts are disabled are parked in the accumulator and leave the pending word untouched. Software posts always go to the accumulator. The accumulator is merged into the pending word only when an enable command executes.

Top module: `prio_intc`

## Requirements
- R1: Channels are 1..15. A request on bit 0 from any source (device, software or mask) never produces a dispatch, and a dispatched channel number is never 0.
- R2: A pending channel whose enable-mask bit is 0 is never dispatched. Once its mask bit is set, it is dispatched at the next boundary where interrupts are enabled.
- R3: When several enabled channels are pending at the same boundary, the highest-numbered one is dispatched. The others stay pending.
- R4: A device request made while interrupts are disabled is held in the accumulator and does not change the pending word, so no dispatch follows from it. It becomes pending when an enable command executes, and the accumulator is then empty.
- R5: While interrupts are enabled, a device request raised in the same cycle as a boundary is recognised at that boundary.
- R6: A software-posted request is never dispatched before the next enable command, even if interrupts are already enabled.
- R7: `int_en` is 0 after reset. It becomes 1 the cycle after `ei_cmd`. It becomes 0 the cycle after `di_cmd` (disable wins over a simultaneous enable). It is 0 in the cycle the dispatch strobe is high.
- R8: On a dispatch, `save_addr` equals octal 500 and `save_pc` equals `cur_pc` sampled at the boundary.
- R9: On a dispatch of channel N, `vec_addr` equals octal 501 + (15 − N). Channel 15 uses octal 501 and channel 1 uses octal 517.
- R10: `parity_err` raises channel 15.
- R11: If `mid_insn` is 1 at the boundary, `save_pc` equals `insn_pc` (the address of the interrupted instruction) instead of `cur_pc`.
- R12: `take` is high for exactly one cycle, the cycle after the boundary edge. The dispatched channel's pending bit is cleared at that edge.
- R13: Reset clears the mask, pending and accumulator words and `take`, and leaves interrupts disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | 16 | Device request bits, bit N for channel N |
| parity_err | input | 1 | Memory parity error, raises channel 15 |
| sw_post | input | 1 | Software post strobe |
| sw_bits | input | 16 | Bits ORed in by the software post |
| mask_wr | input | 1 | Enable-mask write strobe |
| mask_data | input | 16 | New enable mask |
| ei_cmd | input | 1 | Enable-interrupts command |
| di_cmd | input | 1 | Disable-interrupts command |
| insn_boundary | input | 1 | Instruction boundary (interrupt take point) |
| mid_insn | input | 1 | Take point lies inside a multi-step instruction |
| cur_pc | input | 16 | Current program counter |
| insn_pc | input | 16 | Address of the instruction in progress |
| int_en | output | 1 | Interrupts enabled |
| take | output | 1 | One-cycle dispatch strobe |
| take_chan | output | 4 | Dispatched channel number |
| save_addr | output | 16 | Address where the PC is written |
| save_pc | output | 16 | PC value to write |
| vec_addr | output | 16 | Handler pointer fetch address |

## Verification
The hardest state to reach is a request held back while another path is live. Examples are a device bit parked in the accumulator behind a disable command, or a software post that sits unrecognised while interrupts are already on. The stimulus reaches these by raising the request, then presenting one or more boundaries and showing that no strobe appears. Only after that does it issue the enable command, and it then expects the strobe at the following boundary. Priority and same-cycle recognition are reached by raising two device bits in the very cycle of a boundary, then re-enabling to collect the loser.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned NCHAN  = 15;
    localparam int unsigned WORD_W = NCHAN + 1;
    localparam int unsigned CHAN_W = $clog2(WORD_W);
    localparam int unsigned ADDR_W = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t SAVE_LOC = addr_t'(16'o500);
    localparam addr_t VEC_BASE = addr_t'(16'o501);
    localparam word_t USABLE   = ~word_t'(1);

    typedef struct packed {
        logic  take;
        chan_t chan;
        addr_t save_addr;
        addr_t save_pc;
        addr_t vec_addr;
    } dispatch_t;

    function automatic addr_t vec_of(chan_t c);
        return VEC_BASE + addr_t'(NCHAN) - addr_t'(c);
    endfunction

    function automatic word_t chan_bit(chan_t c);
        return word_t'(1) << c;
    endfunction
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [W-1:0] higher;

    // higher[i] is set when some bit above i is requesting
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_hi
            if (g == W - 1) begin : g_top
                assign higher[g] = 1'b0;
            end else begin : g_rest
                assign higher[g] = |req[W-1:g+1];
            end
        end
    endgenerate

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i] && !higher[i]) idx = IW'(i);
        end
    end

    always_comb begin
        if (found) assert_winner_requests_R3: assert (req[idx]);
    end
endmodule

// File: rtl/vic_req_regs.sv
module vic_req_regs
    import vic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t dev_word,
    input  logic  sw_post,
    input  word_t sw_bits,
    input  logic  mask_wr,
    input  word_t mask_data,
    input  logic  ei_cmd,
    input  logic  di_cmd,
    input  logic  take_now,
    input  word_t take_bit,
    output word_t mask,
    output word_t pend_eff,
    output logic  en
);
    word_t pend, acc, acc_in, dev_live;

    assign dev_live = en ? (dev_word & USABLE) : '0;
    assign pend_eff = pend | dev_live;
    assign acc_in   = ((sw_post ? sw_bits : '0) | (en ? '0 : dev_word)) & USABLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            pend <= '0;
            acc  <= '0;
            en   <= 1'b0;
        end else begin
            if (mask_wr) mask <= mask_data & USABLE;
            if (ei_cmd) begin
                pend <= (pend_eff | acc | acc_in) & ~take_bit;
                acc  <= '0;
            end else begin
                pend <= pend_eff & ~take_bit;
                acc  <= acc | acc_in;
            end
            if (di_cmd || take_now) en <= 1'b0;
            else if (ei_cmd)        en <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            assert_mask_bit0_R1: assert (mask[0] == 1'b0);
            assert_pend_bit0_R1: assert (pend[0] == 1'b0);
        end
    end

    assert_acc_empty_after_ei_R4: assert property (@(posedge clk) disable iff (rst)
        $past(ei_cmd) |-> acc == '0);

    assert_pend_frozen_while_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!en && !ei_cmd && !take_now) |=> pend == $past(pend));
endmodule

// File: rtl/vic_dispatch.sv
module vic_dispatch
    import vic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      boundary,
    input  logic      en,
    input  word_t     pend_eff,
    input  word_t     mask,
    input  logic      mid_insn,
    input  addr_t     cur_pc,
    input  addr_t     insn_pc,
    output logic      take_now,
    output word_t     take_bit,
    output dispatch_t disp
);
    word_t eligible;
    logic  any;
    chan_t win;

    assign eligible = pend_eff & mask & USABLE;

    vic_prio_enc #(.W(WORD_W), .IW(CHAN_W)) u_enc (
        .req   (eligible),
        .found (any),
        .idx   (win)
    );

    assign take_now = boundary && en && any;
    assign take_bit = take_now ? chan_bit(win) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            disp <= '0;
        end else begin
            disp.take <= take_now;
            if (take_now) begin
                disp.chan      <= win;
                disp.save_addr <= SAVE_LOC;
                disp.save_pc   <= mid_insn ? insn_pc : cur_pc;
                disp.vec_addr  <= vec_of(win);
            end
        end
    end

    assert_no_take_without_boundary_R12: assert property (@(posedge clk) disable iff (rst)
        disp.take |-> $past(boundary));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] dev_req,
    input  logic        parity_err,
    input  logic        sw_post,
    input  logic [15:0] sw_bits,
    input  logic        mask_wr,
    input  logic [15:0] mask_data,
    input  logic        ei_cmd,
    input  logic        di_cmd,
    input  logic        insn_boundary,
    input  logic        mid_insn,
    input  logic [15:0] cur_pc,
    input  logic [15:0] insn_pc,
    output logic        int_en,
    output logic        take,
    output logic [3:0]  take_chan,
    output logic [15:0] save_addr,
    output logic [15:0] save_pc,
    output logic [15:0] vec_addr
);
    word_t     dev_word, mask, pend_eff, take_bit;
    logic      en, take_now;
    dispatch_t disp;

    assign dev_word = word_t'(dev_req) | (word_t'(parity_err) << NCHAN);

    vic_req_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .dev_word  (dev_word),
        .sw_post   (sw_post),
        .sw_bits   (word_t'(sw_bits)),
        .mask_wr   (mask_wr),
        .mask_data (word_t'(mask_data)),
        .ei_cmd    (ei_cmd),
        .di_cmd    (di_cmd),
        .take_now  (take_now),
        .take_bit  (take_bit),
        .mask      (mask),
        .pend_eff  (pend_eff),
        .en        (en)
    );

    vic_dispatch u_disp (
        .clk      (clk),
        .rst      (rst),
        .boundary (insn_boundary),
        .en       (en),
        .pend_eff (pend_eff),
        .mask     (mask),
        .mid_insn (mid_insn),
        .cur_pc   (addr_t'(cur_pc)),
        .insn_pc  (addr_t'(insn_pc)),
        .take_now (take_now),
        .take_bit (take_bit),
        .disp     (disp)
    );

    assign int_en    = en;
    assign take      = disp.take;
    assign take_chan = 4'(disp.chan);
    assign save_addr = 16'(disp.save_addr);
    assign save_pc   = 16'(disp.save_pc);
    assign vec_addr  = 16'(disp.vec_addr);

    assert_take_disables_R7: assert property (@(posedge clk) disable iff (rst)
        take |-> !int_en);
    assert_take_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(int_en));
    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);
    assert_chan_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        take |-> take_chan != 4'd0);
    assert_save_loc_R8: assert property (@(posedge clk) disable iff (rst)
        take |-> save_addr == 16'o500);
    assert_vec_range_R9: assert property (@(posedge clk) disable iff (rst)
        take |-> (vec_addr >= 16'o501 && vec_addr <= 16'o517));
    assert_di_wins_R7: assert property (@(posedge clk) disable iff (rst)
        di_cmd |=> !int_en);
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dev_req = '0, sw_bits = '0, mask_data = '0, cur_pc = '0, insn_pc = '0;
    logic        parity_err = 0, sw_post = 0, mask_wr = 0, ei_cmd = 0, di_cmd = 0;
    logic        insn_boundary = 0, mid_insn = 0;
    logic        int_en, take;
    logic [3:0]  take_chan;
    logic [15:0] save_addr, save_pc, vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst(rst), .dev_req(dev_req), .parity_err(parity_err),
        .sw_post(sw_post), .sw_bits(sw_bits), .mask_wr(mask_wr), .mask_data(mask_data),
        .ei_cmd(ei_cmd), .di_cmd(di_cmd), .insn_boundary(insn_boundary),
        .mid_insn(mid_insn), .cur_pc(cur_pc), .insn_pc(insn_pc),
        .int_en(int_en), .take(take), .take_chan(take_chan), .save_addr(save_addr),
        .save_pc(save_pc), .vec_addr(vec_addr)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        dev_req = '0; sw_bits = '0; sw_post = 0; mask_wr = 0; ei_cmd = 0; di_cmd = 0;
        insn_boundary = 0; mid_insn = 0; parity_err = 0;
    endtask

    task automatic set_mask(logic [15:0] m);
        mask_wr = 1; mask_data = m; step(); idle();
    endtask

    task automatic enable();
        ei_cmd = 1; step(); idle();
    endtask

    task automatic boundary(logic [15:0] pc);
        insn_boundary = 1; cur_pc = pc; insn_pc = pc - 16'd4; step(); idle();
    endtask

    task automatic expect_take(string req, int chan, int pc);
        check({req, " take"}, take, 1);
        check({req, " chan"}, take_chan, chan);
        check({req, " save_addr R8"}, save_addr, 'o500);
        check({req, " save_pc"}, save_pc, pc);
        check({req, " vec R9"}, vec_addr, 'o501 + 15 - chan);
        check({req, " int_en off R7"}, int_en, 0);
        step();
        check({req, " strobe one cycle R12"}, take, 0);
    endtask

    task automatic test_reset_R13();
        check("R13 take", take, 0);
        check("R13 int_en", int_en, 0);
        enable();
        boundary(16'h0100);
        check("R13 nothing pending", take, 0);
        di_cmd = 1; step(); idle();
    endtask

    task automatic test_accum_R4();
        set_mask(16'hFFFE);
        dev_req = 16'h0008; step(); idle();
        boundary(16'h1000);
        check("R4 no take while off", take, 0);
        enable();
        check("R7 enabled", int_en, 1);
        boundary(16'h1234);
        expect_take("R4", 3, 'h1234);
    endtask

    task automatic test_prio_R3();
        enable();
        dev_req = 16'h0220; insn_boundary = 1; cur_pc = 16'h2000; step(); idle();
        expect_take("R3 R5 same-cycle", 9, 'h2000);
        enable();
        boundary(16'h2100);
        expect_take("R3 loser kept", 5, 'h2100);
    endtask

    task automatic test_mask_R2();
        set_mask(16'hFF7E);
        enable();
        dev_req = 16'h0080; step(); idle();
        boundary(16'h3000);
        check("R2 masked no take", take, 0);
        set_mask(16'hFFFE);
        boundary(16'h3004);
        expect_take("R2 unmasked", 7, 'h3004);
    endtask

    task automatic test_bit0_R1();
        set_mask(16'hFFFF);
        enable();
        dev_req = 16'h0001; step(); idle();
        boundary(16'h4000);
        check("R1 device bit0", take, 0);
        sw_post = 1; sw_bits = 16'h0001; step(); idle();
        enable();
        boundary(16'h4004);
        check("R1 software bit0", take, 0);
        set_mask(16'hFFFE);
    endtask

    task automatic test_sw_R6();
        sw_post = 1; sw_bits = 16'h0010; step(); idle();
        check("R6 still enabled", int_en, 1);
        boundary(16'h5000);
        check("R6 no take before ei", take, 0);
        enable();
        boundary(16'h5004);
        expect_take("R6", 4, 'h5004);
    endtask

    task automatic test_parity_R10();
        enable();
        parity_err = 1; insn_boundary = 1; cur_pc = 16'h6000; step(); idle();
        expect_take("R10", 15, 'h6000);
    endtask

    task automatic test_mid_R11();
        enable();
        dev_req = 16'h0002; step(); idle();
        insn_boundary = 1; mid_insn = 1; cur_pc = 16'h2000; insn_pc = 16'h1FFC; step(); idle();
        expect_take("R11 backed-up pc, channel 1", 1, 'h1FFC);
    endtask

    task automatic test_di_R7();
        enable();
        ei_cmd = 1; di_cmd = 1; step(); idle();
        check("R7 di wins", int_en, 0);
        dev_req = 16'h0004; step(); idle();
        boundary(16'h7000);
        check("R7 disabled no take", take, 0);
        enable();
        boundary(16'h7004);
        expect_take("R7 R4 parked request", 2, 'h7004);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        test_reset_R13();
        test_accum_R4();
        test_prio_R3();
        test_mask_R2();
        test_bit0_R1();
        test_sw_R6();
        test_parity_R10();
        test_mid_R11();
        test_di_R7();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule